// File: doc/BRIEF.md
# Batch-Ranked DRAM Request Scheduler

This block picks which queued DRAM request goes out next when requests from several hardware threads compete for several banks. Requests enter through a one-per-cycle enqueue port. Each request carries a thread ID, a bank and a row, and it waits in a small slot queue where it ages by one every cycle. Each cycle in which the issue slot is free, one request leaves on the grant port. DRAM timing is not modelled here. An outside timing tracker drives `issue_ok`, and a grant counts as completion of the request.

The scheduler works in batches. When none of the queued requests is a batch member, the block spends one cycle building a new batch. For every (thread, bank) pair it tags up to `RCAP` of the oldest waiting requests. In the same cycle it ranks the threads by how heavily they load the batch: the largest per-bank member count comes first and the total member count breaks ties. A lighter thread gets a better rank. Batch members always beat non-members. Within each class the order is:
1. a hit on the bank's open row;
2. better thread rank;
3. greater age.

Top module: `batch_rank_sched`

## Requirements
- R1: The queue has `NSLOTS` slots. `enq_ready` is high exactly when at least one slot is free, and an accepted request goes into the lowest-numbered free slot with age 0. A freed slot can be reused only from the cycle after its grant.
- R2: A cycle in which the queue is non-empty and holds no batch member is a formation cycle, in which no grant is given. In that cycle each (thread, bank) pair tags its `RCAP` oldest requests, or all of them if it has fewer. Here "older" means a larger age, with the lower slot winning an equal age.
- R3: When any batch member is waiting, the grant goes to a batch member.
- R4: Among candidates of equal batch membership, a request whose row equals its bank's open row wins. A bank's open row is the row of the last request granted to that bank, and no bank has an open row after reset.
- R5: Next comes thread rank. Each thread has a key made of its largest per-bank member count, then its total member count, both taken at formation and held until the next formation. The lower key wins, and equal keys go to the lower thread ID.
- R6: Next comes age, where the larger age wins. Age counts cycles spent in the queue and saturates at 2^`AGE_W`-1. The lower slot number settles any remaining tie.
- R7: A grant occurs only in a cycle with `issue_ok` high, and then whenever a request is queued and the cycle is not a formation cycle. The granted request leaves the queue at that clock edge.
- R8: After reset the queue is empty, no bank is open, `gnt_valid` is low and `enq_ready` is high.
- R9: Requests that arrive while a batch is in progress stay non-members until the next formation.
- R10: A new batch is formed only once every member of the previous batch has been granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | New request offered |
| enq_thread | input | TID_W | Thread ID of the offered request |
| enq_bank | input | BANK_W | Target bank |
| enq_row | input | ROW_W | Target row |
| enq_ready | output | 1 | A slot is free; the offer is taken at the clock edge |
| issue_ok | input | 1 | Command slot available this cycle |
| gnt_valid | output | 1 | A request is granted this cycle |
| gnt_thread | output | TID_W | Thread ID of the granted request |
| gnt_bank | output | BANK_W | Bank of the granted request |
| gnt_row | output | ROW_W | Row of the granted request |

## Verification
The hardest situation to reach from the ports is a batch in which a request that is both a row hit and lower-ranked must lose to, or beat, members of another thread. That requires the open rows and the batch membership to be set up by earlier grants. Reaching it needs a formation cycle that happens on purpose. The directed sequences therefore first enqueue a single blocker request, which forms a batch on its own. With the blocker holding the batch, the interesting requests are queued as non-members. Granting the blocker then forces a formation over exactly the requests the test wants. Random traffic uses a small row range so that hits are frequent, and it is compared cycle by cycle against a bench model of the ordering rules.

// File: rtl/brs_pkg.sv
package brs_pkg;
    parameter int NSLOTS = 8;
    parameter int NTHR   = 4;
    parameter int NBANK  = 4;
    parameter int ROW_W  = 8;
    parameter int AGE_W  = 8;
    parameter int RCAP   = 2;

    localparam int TID_W  = $clog2(NTHR);
    localparam int BANK_W = $clog2(NBANK);
    localparam int SLOT_W = $clog2(NSLOTS);
    localparam int CNT_W  = $clog2(NSLOTS + 1);
    localparam int KEY_W  = 2 * CNT_W;
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    typedef struct packed {
        logic              vld;
        logic              mrk;
        logic [TID_W-1:0]  tid;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [AGE_W-1:0]  age;
    } slot_t;

    typedef logic [KEY_W-1:0] key_t;
    typedef slot_t [NSLOTS-1:0] slot_vec_t;
    typedef key_t [NTHR-1:0] key_vec_t;
endpackage

// File: rtl/brs_batch_marker.sv
module brs_batch_marker
    import brs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              form_i,
    input  slot_vec_t         slots_i,
    output logic [NSLOTS-1:0] mark_o,
    output key_vec_t          keys_o
);
    logic [CNT_W-1:0] cap_max;

    // Tag the RCAP oldest requests of each (thread, bank) pair.
    always_comb begin
        for (int i = 0; i < NSLOTS; i++) begin
            logic [CNT_W-1:0] older_cnt;
            older_cnt = '0;
            for (int j = 0; j < NSLOTS; j++) begin
                if (j != i && slots_i[j].vld &&
                    slots_i[j].tid == slots_i[i].tid &&
                    slots_i[j].bank == slots_i[i].bank &&
                    (slots_i[j].age > slots_i[i].age ||
                     (slots_i[j].age == slots_i[i].age && j < i)))
                    older_cnt = older_cnt + 1'b1;
            end
            mark_o[i] = slots_i[i].vld && (older_cnt < CNT_W'(RCAP));
        end
    end

    // Per-thread load key: {largest per-bank count, total count}.
    always_comb begin
        cap_max = '0;
        for (int t = 0; t < NTHR; t++) begin
            logic [CNT_W-1:0] mx;
            logic [CNT_W-1:0] tot;
            mx  = '0;
            tot = '0;
            for (int b = 0; b < NBANK; b++) begin
                logic [CNT_W-1:0] c;
                c = '0;
                for (int i = 0; i < NSLOTS; i++) begin
                    if (mark_o[i] && slots_i[i].tid == TID_W'(t) &&
                        slots_i[i].bank == BANK_W'(b))
                        c = c + 1'b1;
                end
                if (c > mx) mx = c;
                tot = tot + c;
            end
            if (mx > cap_max) cap_max = mx;
            keys_o[t] = {mx, tot};
        end
    end

    a_r2_cap_per_pair: assert property (@(posedge clk) disable iff (!rst_n)
        form_i |-> (cap_max <= CNT_W'(RCAP)));
endmodule

// File: rtl/brs_picker.sv
module brs_picker
    import brs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slot_vec_t         slots_i,
    input  logic [NSLOTS-1:0] hit_i,
    input  key_vec_t          keys_i,
    output logic              any_o,
    output logic [SLOT_W-1:0] idx_o
);
    function automatic logic beats(slot_t a, logic ah, key_t ak,
                                   slot_t b, logic bh, key_t bk);
        if (a.mrk != b.mrk) return a.mrk;
        if (ah != bh)       return ah;
        if (ak != bk)       return ak < bk;
        if (a.tid != b.tid) return a.tid < b.tid;
        if (a.age != b.age) return a.age > b.age;
        return 1'b0;
    endfunction

    // Ascending scan with strict compare keeps the lower slot on full ties.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (slots_i[i].vld) begin
                if (!any_o || beats(slots_i[i], hit_i[i], keys_i[slots_i[i].tid],
                                    slots_i[idx_o], hit_i[idx_o],
                                    keys_i[slots_i[idx_o].tid])) begin
                    any_o = 1'b1;
                    idx_o = SLOT_W'(i);
                end
            end
        end
    end

    logic [NSLOTS-1:0] member_v;
    logic [NSLOTS-1:0] member_hit_v;
    always_comb begin
        for (int i = 0; i < NSLOTS; i++) begin
            member_v[i]     = slots_i[i].vld && slots_i[i].mrk;
            member_hit_v[i] = member_v[i] && hit_i[i];
        end
    end

    a_r3_member_first: assert property (@(posedge clk) disable iff (!rst_n)
        (any_o && !slots_i[idx_o].mrk) |-> (member_v == '0));
    a_r4_hit_first: assert property (@(posedge clk) disable iff (!rst_n)
        (any_o && slots_i[idx_o].mrk && !hit_i[idx_o]) |-> (member_hit_v == '0));
endmodule

// File: rtl/batch_rank_sched.sv
module batch_rank_sched
    import brs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [TID_W-1:0]  enq_thread,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    output logic              enq_ready,
    input  logic              issue_ok,
    output logic              gnt_valid,
    output logic [TID_W-1:0]  gnt_thread,
    output logic [BANK_W-1:0] gnt_bank,
    output logic [ROW_W-1:0]  gnt_row
);
    typedef struct packed {
        slot_vec_t                   slots;
        logic [NBANK-1:0]            open_vld;
        logic [NBANK-1:0][ROW_W-1:0] open_row;
        key_vec_t                    keys;
    } state_t;

    state_t            st_q, st_d;
    logic [NSLOTS-1:0] valid_v, member_v, hit_v, mark_new;
    key_vec_t          keys_new;
    logic              form_now, pick_any, free_ok;
    logic [SLOT_W-1:0] pick_idx, free_idx;

    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = 0; i < NSLOTS; i++) begin
            valid_v[i]  = st_q.slots[i].vld;
            member_v[i] = st_q.slots[i].vld && st_q.slots[i].mrk;
            hit_v[i]    = st_q.open_vld[st_q.slots[i].bank] &&
                          (st_q.open_row[st_q.slots[i].bank] == st_q.slots[i].row);
            if (!st_q.slots[i].vld && !free_ok) begin
                free_ok  = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
        form_now = (valid_v != '0) && (member_v == '0);
    end

    brs_batch_marker u_marker (
        .clk     (clk),
        .rst_n   (rst_n),
        .form_i  (form_now),
        .slots_i (st_q.slots),
        .mark_o  (mark_new),
        .keys_o  (keys_new)
    );

    brs_picker u_picker (
        .clk     (clk),
        .rst_n   (rst_n),
        .slots_i (st_q.slots),
        .hit_i   (hit_v),
        .keys_i  (st_q.keys),
        .any_o   (pick_any),
        .idx_o   (pick_idx)
    );

    assign enq_ready  = free_ok;
    assign gnt_valid  = issue_ok && !form_now && pick_any;
    assign gnt_thread = st_q.slots[pick_idx].tid;
    assign gnt_bank   = st_q.slots[pick_idx].bank;
    assign gnt_row    = st_q.slots[pick_idx].row;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSLOTS; i++) begin
            if (st_q.slots[i].vld && st_q.slots[i].age != AGE_MAX)
                st_d.slots[i].age = st_q.slots[i].age + 1'b1;
            if (form_now)
                st_d.slots[i].mrk = mark_new[i];
        end
        if (form_now)
            st_d.keys = keys_new;
        if (gnt_valid) begin
            st_d.slots[pick_idx].vld = 1'b0;
            st_d.slots[pick_idx].mrk = 1'b0;
            st_d.open_vld[st_q.slots[pick_idx].bank] = 1'b1;
            st_d.open_row[st_q.slots[pick_idx].bank] = st_q.slots[pick_idx].row;
        end
        if (enq_valid && free_ok) begin
            st_d.slots[free_idx].vld  = 1'b1;
            st_d.slots[free_idx].mrk  = 1'b0;
            st_d.slots[free_idx].tid  = enq_thread;
            st_d.slots[free_idx].bank = enq_bank;
            st_d.slots[free_idx].row  = enq_row;
            st_d.slots[free_idx].age  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r10_marks_only_at_formation: assert property (@(posedge clk) disable iff (!rst_n)
        !form_now |=> ((member_v & ~$past(member_v)) == '0));
    a_r7_granted_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> !st_q.slots[$past(pick_idx)].vld);
endmodule

// File: tb/batch_rank_sched_tb_top.sv
`timescale 1ns/1ps
module batch_rank_sched_tb_top;
    import brs_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enq_valid = 1'b0;
    logic [TID_W-1:0]  enq_thread = '0;
    logic [BANK_W-1:0] enq_bank = '0;
    logic [ROW_W-1:0]  enq_row = '0;
    logic              enq_ready;
    logic              issue_ok = 1'b0;
    logic              gnt_valid;
    logic [TID_W-1:0]  gnt_thread;
    logic [BANK_W-1:0] gnt_bank;
    logic [ROW_W-1:0]  gnt_row;

    always #4 clk = ~clk;

    batch_rank_sched dut_i (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_thread(enq_thread),
        .enq_bank(enq_bank), .enq_row(enq_row), .enq_ready(enq_ready),
        .issue_ok(issue_ok), .gnt_valid(gnt_valid), .gnt_thread(gnt_thread),
        .gnt_bank(gnt_bank), .gnt_row(gnt_row)
    );

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    // reference model
    bit m_vld [NSLOTS];
    bit m_mrk [NSLOTS];
    int m_tid [NSLOTS];
    int m_bank[NSLOTS];
    int m_row [NSLOTS];
    int m_age [NSLOTS];
    bit m_ovld[NBANK];
    int m_orow[NBANK];
    int m_kmax[NTHR];
    int m_ktot[NTHR];

    int obs_gv, obs_t, obs_b, obs_r;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit m_hit(int i);
        return m_ovld[m_bank[i]] && m_orow[m_bank[i]] == m_row[i];
    endfunction

    function automatic bit m_beats(int a, int b);
        if (m_mrk[a] != m_mrk[b]) return m_mrk[a];
        if (m_hit(a) != m_hit(b)) return m_hit(a);
        if (m_kmax[m_tid[a]] != m_kmax[m_tid[b]]) return m_kmax[m_tid[a]] < m_kmax[m_tid[b]];
        if (m_ktot[m_tid[a]] != m_ktot[m_tid[b]]) return m_ktot[m_tid[a]] < m_ktot[m_tid[b]];
        if (m_tid[a] != m_tid[b]) return m_tid[a] < m_tid[b];
        if (m_age[a] != m_age[b]) return m_age[a] > m_age[b];
        return 0;
    endfunction

    task automatic m_form();
        bit nm[NSLOTS];
        for (int i = 0; i < NSLOTS; i++) begin
            int c = 0;
            for (int j = 0; j < NSLOTS; j++)
                if (j != i && m_vld[j] && m_tid[j] == m_tid[i] && m_bank[j] == m_bank[i] &&
                    (m_age[j] > m_age[i] || (m_age[j] == m_age[i] && j < i))) c++;
            nm[i] = m_vld[i] && c < RCAP;
        end
        for (int t = 0; t < NTHR; t++) begin
            m_kmax[t] = 0; m_ktot[t] = 0;
            for (int b = 0; b < NBANK; b++) begin
                int c = 0;
                for (int i = 0; i < NSLOTS; i++)
                    if (nm[i] && m_tid[i] == t && m_bank[i] == b) c++;
                if (c > m_kmax[t]) m_kmax[t] = c;
                m_ktot[t] += c;
            end
        end
        for (int i = 0; i < NSLOTS; i++) m_mrk[i] = nm[i];
    endtask

    task automatic step(bit ev, int et, int eb, int er, bit iss);
        bit form, any, fok, any_m, egv;
        int idx, fidx;
        @(negedge clk);
        enq_valid = ev; enq_thread = TID_W'(et); enq_bank = BANK_W'(eb);
        enq_row = ROW_W'(er); issue_ok = iss;
        #1;
        any_m = 0; any = 0; idx = 0; fok = 0; fidx = 0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (m_vld[i] && m_mrk[i]) any_m = 1;
            if (!m_vld[i] && !fok) begin fok = 1; fidx = i; end
            if (m_vld[i] && (!any || m_beats(i, idx))) begin any = 1; idx = i; end
        end
        form = any && !any_m;
        egv = iss && !form && any;
        chk(enq_ready == fok, "R1 enq_ready", enq_ready, fok);
        chk(gnt_valid == egv, form ? "R2 formation gnt_valid" : "R7 gnt_valid", gnt_valid, egv);
        if (egv && gnt_valid)
            chk(gnt_thread == m_tid[idx] && gnt_bank == m_bank[idx] && gnt_row == m_row[idx],
                "R3/R4/R5/R6 grant {thr,bank,row}",
                {gnt_thread, gnt_bank, gnt_row},
                {TID_W'(m_tid[idx]), BANK_W'(m_bank[idx]), ROW_W'(m_row[idx])});
        obs_gv = gnt_valid; obs_t = gnt_thread; obs_b = gnt_bank; obs_r = gnt_row;
        // model update
        if (form) m_form();
        for (int i = 0; i < NSLOTS; i++)
            if (m_vld[i] && m_age[i] < (1 << AGE_W) - 1) m_age[i]++;
        if (egv) begin
            m_vld[idx] = 0; m_mrk[idx] = 0;
            m_ovld[m_bank[idx]] = 1; m_orow[m_bank[idx]] = m_row[idx];
        end
        if (ev && fok) begin
            m_vld[fidx] = 1; m_mrk[fidx] = 0; m_tid[fidx] = et;
            m_bank[fidx] = eb; m_row[fidx] = er; m_age[fidx] = 0;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        int seed;
        seed = 32'h5eed_0b17;
        void'($urandom(seed));
        for (int i = 0; i < NSLOTS; i++) begin
            m_vld[i] = 0; m_mrk[i] = 0; m_tid[i] = 0; m_bank[i] = 0; m_row[i] = 0; m_age[i] = 0;
        end
        for (int b = 0; b < NBANK; b++) begin m_ovld[b] = 0; m_orow[b] = 0; end
        for (int t = 0; t < NTHR; t++) begin m_kmax[t] = 0; m_ktot[t] = 0; end

        issue_ok = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(gnt_valid == 0, "R8 reset gnt_valid", gnt_valid, 0);
        chk(enq_ready == 1, "R8 reset enq_ready", enq_ready, 1);
        rst_n = 1'b1;

        // Scenario A: row hit beats lighter thread
        step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        step(1, 1, 0, 2, 0);
        step(0, 0, 0, 0, 1);
        chk(obs_gv == 1 && obs_t == 0 && obs_r == 1, "R3 lone member granted", obs_r, 1);
        step(0, 0, 0, 0, 1);
        chk(obs_gv == 0, "R10 formation after batch drained", obs_gv, 0);
        step(0, 0, 0, 0, 1);
        chk(obs_t == 0 && obs_r == 1, "R4 hit beats better rank", obs_t, 0);
        step(0, 0, 0, 0, 1);
        chk(obs_t == 0 && obs_r == 1, "R4 second hit", obs_t, 0);
        step(0, 0, 0, 0, 1);
        chk(obs_t == 1 && obs_r == 2, "R2 capped pair done", obs_t, 1);

        // Scenario B: rank then age, no hits
        step(1, 0, 3, 9, 0);
        step(1, 2, 1, 4, 0);
        step(1, 2, 2, 5, 0);
        step(1, 1, 2, 6, 0);
        step(0, 0, 0, 0, 1);
        chk(obs_t == 0 && obs_b == 3, "R3 blocker granted", obs_b, 3);
        step(0, 0, 0, 0, 1);
        chk(obs_gv == 0, "R2 formation cycle", obs_gv, 0);
        step(0, 0, 0, 0, 1);
        chk(obs_t == 1 && obs_r == 6, "R5 lighter thread first", obs_t, 1);
        step(0, 0, 0, 0, 1);
        chk(obs_t == 2 && obs_r == 4, "R6 older request first", obs_r, 4);
        step(0, 0, 0, 0, 1);
        chk(obs_t == 2 && obs_r == 5, "R6 remaining request", obs_r, 5);

        // Scenario C: late arrival that hits stays outside batch
        step(1, 0, 3, 8, 0);
        step(1, 1, 0, 2, 0);
        step(1, 3, 1, 7, 0);
        step(0, 0, 0, 0, 1);
        chk(obs_gv == 1 && obs_t == 0 && obs_r == 8, "R9 member beats late hit", obs_t, 0);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            step(($urandom % 2) == 0, $urandom % NTHR, $urandom % NBANK, $urandom % 4,
                 ($urandom % 5) < 2);
        end
        for (int k = 0; k < 40; k++) step(0, 0, 0, 0, 1);
        summary();
    end
endmodule